// File: doc/BRIEF.md
# Reservation Monitor for Load-Reserved / Store-Conditional

This block is a small shared memory with several requester ports. Each port can issue plain loads, plain stores, granule-zero operations and the two halves of an optimistic atomic sequence: a load-reserved that reads a word and arms a reservation, and a store-conditional that writes only if that reservation is still intact. The block watches every write path into memory and cancels reservations whose granule is touched by another agent. A store-conditional therefore commits only when no other agent has modified the protected block since the load-reserved. Each store-conditional returns a pass or fail flag, so software can retry the sequence.

A reservation covers an aligned granule of `GRAN_BYTES` bytes. The default is 32 bytes, or eight 32-bit words. Two addresses fall in the same granule when their bits above bit 4 are equal. Requests that arrive in the same cycle are handled as if issued one after another in port order, lowest index first. A later port sees both the data and the reservation effects of the earlier ports. An interrupt input is provided, and it never disturbs a reservation.

Top module: `lrsc_monitor`

## Requirements
- R1: For each port, a request with `req_valid` high produces `rsp_valid` high exactly one clock later, and an idle port gives `rsp_valid` low. A plain load (op 0) returns the 32-bit word at `addr[ADDR_W-1:2]` on `rsp_rdata`.
- R2: A load-reserved (op 3) to a word-aligned address returns the word and gives the issuing port a reservation on the granule containing that address.
- R3: A port holds at most one reservation. A new load-reserved from the same port replaces the earlier one, so the old granule is no longer protected.
- R4: A store-conditional (op 4) writes `req_wdata` and returns `rsp_sc_ok`=1 only if the issuing port holds a valid reservation on the granule containing the address. Otherwise memory is unchanged and `rsp_sc_ok`=0.
- R5: Every word-aligned store-conditional clears the issuing port's reservation, whether it passes or fails and whether or not its granule matches.
- R6: A plain store (op 1) or granule-zero (op 2) from a different port into a reserved granule cancels that reservation. The holder's own plain store does not cancel it, and writes to other granules do not cancel it.
- R7: A passing store-conditional cancels every other port's reservation on the same granule.
- R8: A granule-zero writes zero to every word of the granule containing the address and leaves neighbouring granules untouched.
- R9: A load-reserved or store-conditional whose `addr[1:0]` is not 00 returns `rsp_err`=1, `rsp_sc_ok`=0 and `rsp_rdata`=0. It writes nothing and leaves every reservation as it was.
- R10: `irq_in` has no effect on reservations, memory or responses.
- R11: Same-cycle requests are handled in ascending port order. Each port sees the memory writes and reservation changes made by lower-index ports in that cycle.
- R12: Reset clears all reservations and all memory words, and holds `rsp_valid` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 1 | Interrupt indication; has no effect on reservations |
| req_valid | input | NPORTS | Request strobe, one bit per port |
| req_op | input | NPORTS x 3 | Operation code per port: 0 load, 1 store, 2 zero, 3 load-reserved, 4 store-conditional |
| req_addr | input | NPORTS x ADDR_W | Byte address per port |
| req_wdata | input | NPORTS x 32 | Store data per port |
| rsp_valid | output | NPORTS | Response strobe, one cycle after the request |
| rsp_rdata | output | NPORTS x 32 | Read data for loads and load-reserved, otherwise zero |
| rsp_sc_ok | output | NPORTS | Store-conditional pass flag |
| rsp_err | output | NPORTS | Misalignment error for load-reserved / store-conditional |

## Verification
Every result (read data, the pass flag and the error flag) is registered once and appears in the cycle after the request edge. Reservation and memory effects are visible to any request issued in the next cycle, or to later-index ports in the same cycle. The bench drives a request just after a falling edge and pushes the expected result into a per-port queue. The monitor pops that queue at the following falling edge, half a cycle after the response register has loaded. This keeps every comparison at the one-cycle latency, and a leftover or missing response is reported as a failure.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;

  localparam int unsigned WORD_W = 32;

  typedef enum logic [2:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_ZERO  = 3'd2,
    OP_LR    = 3'd3,
    OP_SC    = 3'd4
  } op_e;

  // granule tag: byte address with the granule offset stripped
  function automatic int unsigned tag_of(int unsigned addr, int unsigned gran_lg2);
    return addr >> gran_lg2;
  endfunction

  // word index inside the array
  function automatic int unsigned word_of(int unsigned addr);
    return addr >> 2;
  endfunction

  function automatic logic misaligned(logic [1:0] low_bits);
    return low_bits != 2'b00;
  endfunction

endpackage

// File: rtl/lrsc_resv_track.sv
module lrsc_resv_track import lrsc_pkg::*; #(
  parameter int unsigned NP       = 3,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned GRAN_LG2 = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NP-1:0]               req_valid,
  input  logic [NP-1:0][2:0]          req_op,
  input  logic [NP-1:0][ADDR_W-1:0]   req_addr,
  output logic [NP-1:0]               resv_v,
  output logic [NP-1:0]               sc_ok,
  output logic [NP-1:0]               align_err
);
  localparam int unsigned GTAG_W = ADDR_W - GRAN_LG2;

  logic [NP-1:0][GTAG_W-1:0] resv_tag;
  logic [NP-1:0][GTAG_W-1:0] nxt_tag;
  logic [NP-1:0]             nxt_v;
  logic [NP-1:0][GTAG_W-1:0] req_tag;
  logic [NP-1:0]             mis;

  for (genvar g = 0; g < NP; g++) begin : g_dec
    assign req_tag[g] = GTAG_W'(tag_of(32'(req_addr[g]), GRAN_LG2));
    assign mis[g]     = misaligned(req_addr[g][1:0]);
  end

  // ports are walked in ascending order so later ports see earlier effects
  always_comb begin
    nxt_v     = resv_v;
    nxt_tag   = resv_tag;
    sc_ok     = '0;
    align_err = '0;
    for (int i = 0; i < NP; i++) begin
      if (req_valid[i]) begin
        if (req_op[i] == OP_LR) begin
          if (mis[i]) begin
            align_err[i] = 1'b1;
          end else begin
            nxt_v[i]   = 1'b1;
            nxt_tag[i] = req_tag[i];
          end
        end else if (req_op[i] == OP_SC) begin
          if (mis[i]) begin
            align_err[i] = 1'b1;
          end else begin
            sc_ok[i] = nxt_v[i] && (nxt_tag[i] == req_tag[i]);
            nxt_v[i] = 1'b0;
            if (sc_ok[i]) begin
              for (int j = 0; j < NP; j++) begin
                if (j != i && nxt_tag[j] == req_tag[i]) nxt_v[j] = 1'b0;
              end
            end
          end
        end else if (req_op[i] == OP_STORE || req_op[i] == OP_ZERO) begin
          for (int j = 0; j < NP; j++) begin
            if (j != i && nxt_tag[j] == req_tag[i]) nxt_v[j] = 1'b0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resv_v   <= '0;
      resv_tag <= '0;
    end else begin
      resv_v   <= nxt_v;
      resv_tag <= nxt_tag;
    end
  end

endmodule

// File: rtl/lrsc_word_mem.sv
module lrsc_word_mem import lrsc_pkg::*; #(
  parameter int unsigned NP       = 3,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned GRAN_LG2 = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NP-1:0]               req_valid,
  input  logic [NP-1:0][2:0]          req_op,
  input  logic [NP-1:0][ADDR_W-1:0]   req_addr,
  input  logic [NP-1:0][WORD_W-1:0]   req_wdata,
  input  logic [NP-1:0]               sc_ok,
  output logic [NP-1:0][WORD_W-1:0]   rd_data
);
  localparam int unsigned WIDX_W = ADDR_W - 2;
  localparam int unsigned WORDS  = 1 << WIDX_W;
  localparam int unsigned GTAG_W = ADDR_W - GRAN_LG2;

  logic [WORD_W-1:0]         mem [WORDS];
  logic [NP-1:0][WIDX_W-1:0] widx;
  logic [NP-1:0][GTAG_W-1:0] gtag;
  logic [NP-1:0]             wr_en;
  logic [NP-1:0]             zr_en;

  for (genvar g = 0; g < NP; g++) begin : g_dec
    assign widx[g]  = WIDX_W'(word_of(32'(req_addr[g])));
    assign gtag[g]  = GTAG_W'(tag_of(32'(req_addr[g]), GRAN_LG2));
    assign wr_en[g] = req_valid[g] &&
                      (req_op[g] == OP_STORE || (req_op[g] == OP_SC && sc_ok[g]));
    assign zr_en[g] = req_valid[g] && req_op[g] == OP_ZERO;
  end

  // read data forwarded from lower-index writes of the same cycle
  always_comb begin
    for (int i = 0; i < NP; i++) begin
      rd_data[i] = mem[widx[i]];
      for (int j = 0; j < NP; j++) begin
        if (j < i) begin
          if (wr_en[j] && widx[j] == widx[i]) rd_data[i] = req_wdata[j];
          if (zr_en[j] && gtag[j] == gtag[i]) rd_data[i] = '0;
        end
      end
    end
  end

  // later ports are applied last so their writes win
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < WORDS; w++) mem[w] <= '0;
    end else begin
      for (int i = 0; i < NP; i++) begin
        if (wr_en[i]) mem[widx[i]] <= req_wdata[i];
        if (zr_en[i]) begin
          for (int w = 0; w < WORDS; w++) begin
            if (GTAG_W'(tag_of(32'(w) << 2, GRAN_LG2)) == gtag[i]) mem[w] <= '0;
          end
        end
      end
    end
  end

endmodule

// File: rtl/lrsc_monitor.sv
module lrsc_monitor import lrsc_pkg::*; #(
  parameter int unsigned NPORTS     = 3,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned GRAN_BYTES = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          irq_in,
  input  logic [NPORTS-1:0]             req_valid,
  input  logic [NPORTS-1:0][2:0]        req_op,
  input  logic [NPORTS-1:0][ADDR_W-1:0] req_addr,
  input  logic [NPORTS-1:0][WORD_W-1:0] req_wdata,
  output logic [NPORTS-1:0]             rsp_valid,
  output logic [NPORTS-1:0][WORD_W-1:0] rsp_rdata,
  output logic [NPORTS-1:0]             rsp_sc_ok,
  output logic [NPORTS-1:0]             rsp_err
);
  localparam int unsigned GRAN_LG2 = $clog2(GRAN_BYTES);

  // named internal events for the checker
  logic [NPORTS-1:0]             resv_v;
  logic [NPORTS-1:0]             sc_commit;
  logic [NPORTS-1:0]             align_err;
  logic [NPORTS-1:0][WORD_W-1:0] rd_data;

  lrsc_resv_track #(.NP(NPORTS), .ADDR_W(ADDR_W), .GRAN_LG2(GRAN_LG2)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_addr  (req_addr),
    .resv_v    (resv_v),
    .sc_ok     (sc_commit),
    .align_err (align_err)
  );

  lrsc_word_mem #(.NP(NPORTS), .ADDR_W(ADDR_W), .GRAN_LG2(GRAN_LG2)) u_mem (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .sc_ok     (sc_commit),
    .rd_data   (rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= '0;
      rsp_rdata <= '0;
      rsp_sc_ok <= '0;
      rsp_err   <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_sc_ok <= sc_commit & req_valid;
      rsp_err   <= align_err & req_valid;
      for (int i = 0; i < NPORTS; i++) begin
        if (req_valid[i] && (req_op[i] == OP_LOAD ||
                             (req_op[i] == OP_LR && !align_err[i])))
          rsp_rdata[i] <= rd_data[i];
        else
          rsp_rdata[i] <= '0;
      end
    end
  end

endmodule

// File: rtl/lrsc_monitor_chk.sv
module lrsc_monitor_chk import lrsc_pkg::*; #(
  parameter int unsigned NP     = 3,
  parameter int unsigned ADDR_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    irq_in,
  input logic [NP-1:0]           req_valid,
  input logic [NP-1:0][2:0]      req_op,
  input logic [NP-1:0][ADDR_W-1:0] req_addr,
  input logic [NP-1:0]           rsp_valid,
  input logic [NP-1:0]           rsp_sc_ok,
  input logic [NP-1:0]           rsp_err,
  input logic [NP-1:0]           resv_v
);

  for (genvar p = 0; p < NP; p++) begin : g_port
    // R1
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid[p] |=> rsp_valid[p]);
    // R1
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid[p] |=> !rsp_valid[p]);
    // R4
    sc_needs_resv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid[p] && req_op[p] == OP_SC && resv_v[p]) |=> !rsp_sc_ok[p]);
    // R5
    sc_clears_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[p] && req_op[p] == OP_SC && req_addr[p][1:0] == 2'b00) |=> !resv_v[p]);
    // R9
    err_only_misaligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid[p] && (req_op[p] == OP_LR || req_op[p] == OP_SC) &&
        req_addr[p][1:0] != 2'b00) |=> !rsp_err[p]);
    // R9
    err_excludes_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err[p] |-> !rsp_sc_ok[p]);
  end

  // R2
  lr_arms_last_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid[NP-1] && req_op[NP-1] == OP_LR && req_addr[NP-1][1:0] == 2'b00)
    |=> resv_v[NP-1]);

  // R10
  irq_keeps_resv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_in && req_valid == '0) |=> $stable(resv_v));

endmodule

bind lrsc_monitor lrsc_monitor_chk #(.NP(NPORTS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_in    (irq_in),
  .req_valid (req_valid),
  .req_op    (req_op),
  .req_addr  (req_addr),
  .rsp_valid (rsp_valid),
  .rsp_sc_ok (rsp_sc_ok),
  .rsp_err   (rsp_err),
  .resv_v    (resv_v)
);

// File: tb/lrsc_monitor_tb.sv
module lrsc_monitor_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 3;
  localparam int AW = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              irq_in = 1'b0;
  logic [NP-1:0]     req_valid = '0;
  logic [NP-1:0][2:0]  req_op = '0;
  logic [NP-1:0][AW-1:0] req_addr = '0;
  logic [NP-1:0][31:0] req_wdata = '0;
  logic [NP-1:0]     rsp_valid;
  logic [NP-1:0][31:0] rsp_rdata;
  logic [NP-1:0]     rsp_sc_ok;
  logic [NP-1:0]     rsp_err;

  lrsc_monitor #(.NPORTS(NP), .ADDR_W(AW), .GRAN_BYTES(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_sc_ok(rsp_sc_ok), .rsp_err(rsp_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [31:0] rd;
    logic        ok;
    logic        err;
    string       tag;
  } exp_t;

  exp_t exp_q [NP][$];
  int n_tests = 0;
  int n_fail  = 0;

  // bench model state
  logic [31:0] bm_mem [64];
  logic        bm_v [NP];
  int          bm_g [NP];

  // staged requests
  logic        s_v [NP];
  int          s_op [NP];
  int          s_a [NP];
  logic [31:0] s_d [NP];
  string       s_tag [NP];

  task automatic stage(int p, int op, int a, logic [31:0] d, string tag);
    s_v[p] = 1'b1; s_op[p] = op; s_a[p] = a; s_d[p] = d; s_tag[p] = tag;
  endtask

  task automatic kill_others(int p, int g);
    for (int q = 0; q < NP; q++) if (q != p && bm_g[q] == g) bm_v[q] = 1'b0;
  endtask

  task automatic go();
    for (int p = 0; p < NP; p++) begin
      req_valid[p] = s_v[p];
      req_op[p]    = 3'(s_op[p]);
      req_addr[p]  = AW'(s_a[p]);
      req_wdata[p] = s_d[p];
    end
    for (int p = 0; p < NP; p++) begin
      if (s_v[p]) begin
        exp_t e;
        int g, w;
        logic mis;
        g = s_a[p] / 32; w = (s_a[p] / 4) % 64; mis = (s_a[p] % 4) != 0;
        e.rd = 0; e.ok = 0; e.err = 0; e.tag = s_tag[p];
        case (s_op[p])
          0: e.rd = bm_mem[w];
          1: begin bm_mem[w] = s_d[p]; kill_others(p, g); end
          2: begin for (int k = 0; k < 8; k++) bm_mem[g*8+k] = 0; kill_others(p, g); end
          3: if (mis) e.err = 1; else begin e.rd = bm_mem[w]; bm_v[p] = 1; bm_g[p] = g; end
          4: if (mis) e.err = 1; else begin
               e.ok = bm_v[p] && bm_g[p] == g;
               bm_v[p] = 0;
               if (e.ok) begin bm_mem[w] = s_d[p]; kill_others(p, g); end
             end
          default: ;
        endcase
        exp_q[p].push_back(e);
      end
    end
    @(negedge clk);
    req_valid = '0;
    for (int p = 0; p < NP; p++) s_v[p] = 1'b0;
  endtask

  task automatic one(int p, int op, int a, logic [31:0] d, string tag);
    stage(p, op, a, d, tag);
    go();
  endtask

  // monitor: responses are due one edge after the request, sampled at negedge
  always @(negedge clk) begin
    if (rst_n) begin
      for (int p = 0; p < NP; p++) begin
        if (rsp_valid[p]) begin
          n_tests++;
          if (exp_q[p].size() == 0) begin
            n_fail++;
            $display("FAIL R1 port %0d: unexpected response rd=%h ok=%b err=%b, expected none",
                     p, rsp_rdata[p], rsp_sc_ok[p], rsp_err[p]);
          end else begin
            exp_t e;
            e = exp_q[p].pop_front();
            if (rsp_rdata[p] !== e.rd || rsp_sc_ok[p] !== e.ok || rsp_err[p] !== e.err) begin
              n_fail++;
              $display("FAIL %s port %0d: got rd=%h ok=%b err=%b, expected rd=%h ok=%b err=%b",
                       e.tag, p, rsp_rdata[p], rsp_sc_ok[p], rsp_err[p], e.rd, e.ok, e.err);
            end
          end
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int w = 0; w < 64; w++) bm_mem[w] = 0;
    for (int p = 0; p < NP; p++) begin bm_v[p] = 0; bm_g[p] = 0; s_v[p] = 0; end
    repeat (3) @(negedge clk);
    // R12: outputs idle during reset
    n_tests++;
    if (rsp_valid !== '0) begin
      n_fail++;
      $display("FAIL R12: rsp_valid=%b, expected 000", rsp_valid);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R12: reset cleared memory and reservations
    one(0, 0, 'h00, 0, "R12");
    stage(0, 4, 'h00, 32'h1, "R12"); stage(1, 4, 'h20, 32'h2, "R12"); stage(2, 4, 'h40, 32'h3, "R12");
    go();
    one(1, 0, 'h20, 0, "R12");

    // R1: plain store then load
    one(0, 1, 'h10, 32'hA5A5_0001, "R1");
    one(1, 0, 'h10, 0, "R1");

    // R2 / R4: reserve, conditional store into same granule passes
    one(0, 3, 'h10, 0, "R2");
    one(0, 4, 'h14, 32'hBEEF_0002, "R4");
    one(2, 0, 'h14, 0, "R4");
    // R5: reservation gone after the pass
    one(0, 4, 'h14, 32'h0BAD_0003, "R5");
    one(2, 0, 'h14, 0, "R5");

    // R5 / R4: mismatched SC fails, writes nothing, still clears
    one(1, 3, 'h40, 0, "R2");
    one(1, 4, 'h60, 32'h1111_1111, "R4");
    one(1, 0, 'h60, 0, "R4");
    one(1, 4, 'h40, 32'h2222_2222, "R5");

    // R3: replacement of a reservation
    one(2, 3, 'h20, 0, "R3");
    one(2, 3, 'h80, 0, "R3");
    one(2, 4, 'h20, 32'h3333_3333, "R3");
    one(2, 3, 'h80, 0, "R3");
    one(2, 4, 'h84, 32'h4444_4444, "R3");

    // R6: foreign store kills, own store does not, other granule does not
    one(0, 3, 'h20, 0, "R6");
    one(1, 1, 'h3C, 32'h5555_5555, "R6");
    one(0, 4, 'h20, 32'h6666_6666, "R6");
    one(0, 3, 'h20, 0, "R6");
    one(0, 1, 'h24, 32'h7777_7777, "R6");
    one(0, 4, 'h20, 32'h8888_8888, "R6");
    one(1, 3, 'hA0, 0, "R6");
    one(2, 2, 'hA8, 0, "R6");
    one(1, 4, 'hA0, 32'h9999_9999, "R6");
    one(1, 3, 'hA0, 0, "R6");
    one(0, 1, 'hC0, 32'hCCCC_0000, "R6");
    one(1, 4, 'hA0, 32'hAAAA_AAAA, "R6");

    // R7: pass cancels peers on same granule
    one(0, 3, 'h40, 0, "R7");
    one(1, 3, 'h44, 0, "R7");
    one(0, 4, 'h48, 32'h7070_7070, "R7");
    one(1, 4, 'h44, 32'h7171_7171, "R7");

    // R8: granule zero
    one(0, 1, 'hE0, 32'hE0E0_E0E0, "R8");
    one(0, 1, 'hFC, 32'hFCFC_FCFC, "R8");
    one(0, 1, 'hDC, 32'hDCDC_DCDC, "R8");
    one(1, 2, 'hE4, 0, "R8");
    one(0, 0, 'hE0, 0, "R8");
    one(0, 0, 'hFC, 0, "R8");
    one(0, 0, 'hDC, 0, "R8");

    // R9: misaligned LR/SC error, reservation untouched, no write
    one(0, 3, 'h40, 0, "R9");
    one(0, 3, 'h41, 0, "R9");
    one(0, 4, 'h42, 32'hDEAD_0009, "R9");
    one(1, 0, 'h40, 0, "R9");
    one(0, 4, 'h40, 32'h0900_0009, "R9");

    // R11: same-cycle ordering
    stage(0, 1, 'h50, 32'h1100_0011, "R11"); stage(1, 3, 'h50, 0, "R11");
    go();
    one(1, 4, 'h50, 32'h1100_0022, "R11");
    one(2, 3, 'h60, 0, "R11");
    stage(0, 1, 'h60, 32'h1100_0033, "R11"); stage(2, 4, 'h60, 32'h1100_0044, "R11");
    go();
    one(0, 3, 'h70, 0, "R11");
    stage(0, 4, 'h70, 32'h1100_0055, "R11"); stage(1, 1, 'h74, 32'h1100_0066, "R11");
    go();
    stage(0, 3, 'h70, 0, "R11"); stage(1, 1, 'h70, 32'h1100_0077, "R11");
    go();
    one(0, 4, 'h70, 32'h1100_0088, "R11");
    one(2, 0, 'h70, 0, "R11");

    // R10: interrupt does not disturb a reservation
    one(2, 3, 'hC0, 0, "R10");
    irq_in = 1'b1;
    repeat (4) @(negedge clk);
    one(1, 0, 'hC0, 0, "R10");
    irq_in = 1'b0;
    @(negedge clk);
    irq_in = 1'b1;
    one(2, 4, 'hC4, 32'h1010_1010, "R10");
    irq_in = 1'b0;
    one(0, 0, 'hC4, 0, "R10");

    repeat (3) @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      n_tests++;
      if (exp_q[p].size() != 0) begin
        n_fail++;
        $display("FAIL R1 port %0d: %0d responses missing, expected 0", p, exp_q[p].size());
      end
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule